// File: doc/BRIEF.md
# Framed Four-Bit Pattern Detector

This block watches a one-bit serial stream and cuts it into back-to-back groups of four accepted bits. A bit is accepted in any cycle where the valid strobe is high. The first bit of a group is counted from reset, or from the end of the group before it. On the fourth bit of a group, the output goes high in that same cycle when the group, read in arrival order, is one of two target words: 0110 or 1010. The output is a Mealy output, formed from the present state together with the incoming bit.

Once the fourth bit has been taken, the machine goes back to its start state whether the group matched or not. A partial match therefore never carries into the next group. Internally the machine uses the reduced form of the full fifteen-state history table, which has seven states. The current state code is brought out on a debug port.

Top module: `framed_pattern_detector`

## Requirements
- R1: While `rst` is high, `detect` is 0. After a clock edge with `rst` high, `dbg_state` is 0, which is the start of a group.
- R2: `detect` is 1 in a cycle where `in_valid` is 1, the bit is the fourth accepted bit of its group, and the four bits of the group form 0110 or 1010. The bits are written with the earliest arrival on the left.
- R3: `detect` is 0 during the first three accepted bits of a group, and also on a fourth bit that completes any other word.
- R4: After the edge that accepts the fourth bit of a group, `dbg_state` is 0. This holds whether or not a match occurred.
- R5: In a cycle where `in_valid` is 0, `detect` is 0, and `dbg_state` is unchanged after the next edge.
- R6: The accepted stream 0010 0110 1100 1010 0011 gives the detect stream 0000 0001 0000 0001 0000.
- R7: A reset in the middle of a group discards that group, even when `in_valid` is high in the reset cycle. The next accepted bit is the first bit of a new group.
- R8: `dbg_state` encodes what the group has held so far, with no other values in use:
  - 0: no bit yet.
  - 1: one bit, which was 0.
  - 2: one bit, which was 1.
  - 3: two bits, 01 or 10.
  - 4: two bits, 00 or 11.
  - 5: three bits, 011 or 101.
  - 6: three bits, any other value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | High when `in_bit` carries a bit to accept |
| in_bit | input | 1 | Serial data bit |
| detect | output | 1 | Mealy match flag for the fourth bit of a group |
| dbg_state | output | 3 | Present state code, encoded as in R8 |

## Verification
Two things can land in the same cycle. One is the match flag on a fourth bit together with the return to the start state at that edge. The other is a synchronous reset arriving while a valid bit is offered. The first is provoked by groups that end on a target word, after which the bench expects the state code to read 0 on the very next cycle. The second is provoked by random resets over a valid-heavy stream and by a directed mid-group reset. There, the bench expects the offered bit to be dropped, the output to stay low, and the next group to be detected from its own first bit.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
  localparam int STATE_W   = 3;
  localparam int GROUP_LEN = 4;

  // Codes follow the history the group has shown so far.
  typedef enum logic [STATE_W-1:0] {
    ST_START     = 3'd0,
    ST_ONE_ZERO  = 3'd1,
    ST_ONE_ONE   = 3'd2,
    ST_PAIR_LIVE = 3'd3,
    ST_PAIR_DEAD = 3'd4,
    ST_TRIO_HIT  = 3'd5,
    ST_TRIO_DEAD = 3'd6
  } fpd_state_t;
endpackage

// File: rtl/fpd_next_state.sv
module fpd_next_state
  import fpd_pkg::*;
(
  input  fpd_state_t cur,
  input  logic       bit_in,
  output fpd_state_t nxt
);
  always_comb begin
    case (cur)
      ST_START:     nxt = bit_in ? ST_ONE_ONE   : ST_ONE_ZERO;
      ST_ONE_ZERO:  nxt = bit_in ? ST_PAIR_LIVE : ST_PAIR_DEAD;
      ST_ONE_ONE:   nxt = bit_in ? ST_PAIR_DEAD : ST_PAIR_LIVE;
      ST_PAIR_LIVE: nxt = bit_in ? ST_TRIO_HIT  : ST_TRIO_DEAD;
      ST_PAIR_DEAD: nxt = ST_TRIO_DEAD;
      default:      nxt = ST_START;
    endcase
  end
endmodule

// File: rtl/fpd_out_decode.sv
module fpd_out_decode
  import fpd_pkg::*;
(
  input  fpd_state_t cur,
  input  logic       rst,
  input  logic       in_valid,
  input  logic       bit_in,
  output logic       detect
);
  logic last_bit_ok;

  always_comb begin
    case (cur)
      ST_TRIO_HIT: last_bit_ok = ~bit_in;
      default:     last_bit_ok = 1'b0;
    endcase
  end

  assign detect = last_bit_ok & in_valid & ~rst;
endmodule

// File: rtl/fpd_state_reg.sv
module fpd_state_reg
  import fpd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  fpd_state_t d,
  output fpd_state_t q
);
  logic rst_seen;

  always_ff @(posedge clk) begin
    rst_seen <= rst;
    if (rst) begin
      q <= ST_START;
    end else if (en) begin
      q <= d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_seen === 1'b1) begin
      AST_RESET_START: assert (q == ST_START) else $error("reset left state %0d", q); // R1
    end
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q)) else $error("state moved without valid"); // R5
endmodule

// File: rtl/framed_pattern_detector.sv
module framed_pattern_detector
  import fpd_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               in_bit,
  output logic               detect,
  output logic [STATE_W-1:0] dbg_state
);
  fpd_state_t state_q;
  fpd_state_t state_d;

  fpd_next_state u_next (
    .cur    (state_q),
    .bit_in (in_bit),
    .nxt    (state_d)
  );

  fpd_out_decode u_out (
    .cur      (state_q),
    .rst      (rst),
    .in_valid (in_valid),
    .bit_in   (in_bit),
    .detect   (detect)
  );

  fpd_state_reg u_reg (
    .clk (clk),
    .rst (rst),
    .en  (in_valid),
    .d   (state_d),
    .q   (state_q)
  );

  assign dbg_state = state_q;

  AST_DETECT_ENDS_GROUP: assert property (@(posedge clk) disable iff (rst)
    detect |=> (dbg_state == 3'd0)) else $error("no return to start after match"); // R4

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    detect |=> !detect) else $error("detect held two cycles"); // R3

  AST_HIT_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_TRIO_HIT) |->
      ($past(state_q) == ST_PAIR_LIVE || $past(state_q) == ST_TRIO_HIT))
    else $error("hit state reached from wrong history"); // R2

  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (rst)
    dbg_state <= 3'd6) else $error("unused state code %0d", dbg_state); // R8
endmodule

// File: tb/tb_framed_pattern_detector.sv
`timescale 1ns/1ps
module tb_framed_pattern_detector;
  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic       in_bit;
  logic       detect;
  logic [2:0] dbg_state;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference model
  int       pos;
  logic [2:0] hist;
  bit       after_rst;
  bit       after_fourth;
  logic     last_det;

  always #2.5 clk = ~clk;

  framed_pattern_detector dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
    .detect(detect), .dbg_state(dbg_state)
  );

  function automatic int exp_code(int p, logic [2:0] h);
    logic [2:0] w;
    case (p)
      0: return 0;
      1: return h[0] ? 2 : 1;
      2: return (h[1] != h[0]) ? 3 : 4;
      default: begin
        w = h;
        return (w == 3'b011 || w == 3'b101) ? 5 : 6;
      end
    endcase
  endfunction

  function automatic logic exp_det(logic r, logic v, logic b, int p, logic [2:0] h);
    logic [3:0] g;
    g = {h, b};
    return !r && v && p == 3 && (g == 4'b0110 || g == 4'b1010);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(logic r, logic v, logic b);
    logic ed;
    int   ec;
    @(negedge clk);
    rst = r; in_valid = v; in_bit = b;
    #1;
    ec = exp_code(pos, hist);
    if (after_rst)         check(dbg_state == ec[2:0], "R1 state", dbg_state, ec);
    else if (after_fourth) check(dbg_state == ec[2:0], "R4 state", dbg_state, ec);
    else                   check(dbg_state == ec[2:0], "R8 state", dbg_state, ec);
    ed = exp_det(r, v, b, pos, hist);
    if (r)                 check(detect == ed, "R1 detect", detect, ed);
    else if (!v)           check(detect == ed, "R5 detect", detect, ed);
    else if (ed)           check(detect == ed, "R2 detect", detect, ed);
    else                   check(detect == ed, "R3 detect", detect, ed);
    last_det = detect;
    after_rst = r;
    after_fourth = 0;
    if (r) begin
      pos = 0; hist = '0;
    end else if (v) begin
      hist = {hist[1:0], b};
      if (pos == 3) begin
        pos = 0; after_fourth = 1;
      end else pos++;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [19:0] stream;
    logic [19:0] want;
    int unused_seed;
    unused_seed = $urandom(32'h5eed_1234);
    rst = 1; in_valid = 0; in_bit = 0;
    pos = 0; hist = '0; after_rst = 0; after_fourth = 0; last_det = 0;
    step(1, 0, 0);
    step(1, 1, 0);
    step(0, 0, 0);

    // R6 directed stream
    stream = 20'b0010_0110_1100_1010_0011;
    want   = 20'b0000_0001_0000_0001_0000;
    for (int i = 19; i >= 0; i--) begin
      step(0, 1, stream[i]);
      check(last_det == want[i], "R6 stream", last_det, want[i]);
    end

    // R5 gaps inside a matching group
    step(0, 1, 1); step(0, 0, 1); step(0, 0, 0);
    step(0, 1, 0); step(0, 0, 1); step(0, 1, 1);
    step(0, 0, 1); step(0, 1, 0);
    check(last_det == 1'b1, "R5 gapped match", last_det, 1);

    // R7 mid-group reset with valid bit offered
    step(0, 1, 0); step(0, 1, 1);
    step(1, 1, 1);
    check(last_det == 1'b0, "R7 reset cycle", last_det, 0);
    step(0, 1, 0); step(0, 1, 1); step(0, 1, 1); step(0, 1, 0);
    check(last_det == 1'b1, "R7 fresh group", last_det, 1);

    // random traffic, biased toward valid bits
    for (int i = 0; i < 4000; i++) begin
      logic r, v, b;
      r = ($urandom % 100) == 0;
      v = ($urandom % 4) != 0;
      b = $urandom % 2;
      if (($urandom % 3) == 0 && pos == 3) b = 0;
      step(r, v, b);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule